// File: doc/BRIEF.md
# Immediate-Operand Instruction Executor

This unit takes a stream of instruction bytes, one byte per accepted cycle, and runs a small set of 32-bit instructions that carry a four-byte immediate. It holds eight general registers and three status flags (sign, zero, overflow). A word-wide data-memory port lets it read and write the word that a register points to, and store pushed values on a stack.

The supported set has four parts. The first is a group opcode (0x81) whose ModR/M middle field picks add, or, and, subtract, xor or compare, applied to a register or to the memory word it addresses. The second is the one-byte accumulator forms for subtract, and, or, xor and compare. The third is move-immediate into a register (0xb8 to 0xbf) or into a register or memory word (0xc7). The fourth is push-immediate (0x68). Any encoding outside this set raises a sticky error and stops byte intake until reset.

After each instruction retires, a one-cycle `done` pulse lets the surrounding logic inspect the register file through a read-only peek port.

Top module: `immop_exec`

## Requirements
- R1: A byte is taken only in a cycle with `in_valid` and `in_ready` both high, and idle cycles between bytes have no effect. The four immediate bytes arrive least-significant first, so 0a 0b 0c 0d forms 0x0d0c0b0a.
- R2: Opcode 0x81 followed by a ModR/M byte with bits [7:6]=11 applies the operation chosen by bits [5:3] (0 add, 1 or, 4 and, 5 subtract, 6 xor) to the register indexed by bits [2:0] and the immediate, and writes the result back to that register.
- R3: One-byte opcodes 0x2d (subtract), 0x25 (and), 0x0d (or), 0x35 (xor) and 0x3d (compare) work on register 0 and the immediate. No ModR/M byte follows these opcodes.
- R4: Compare (0x3d, or 0x81 with field 7) writes no register and no memory. It sets SF to bit 31 of operand minus immediate, sets ZF when that difference is zero, and sets OF on signed overflow of the subtraction. All other operations leave the flags unchanged.
- R5: With ModR/M bits [7:6]=00, the operand is the memory word at the address held in register [2:0]. The unit raises a read, waits for `mem_rvalid`, then writes the result to the same address. A compare reads and never writes.
- R6: Opcodes 0xb8 to 0xbf load the immediate into the register indexed by the opcode's low three bits.
- R7: Opcode 0xc7 stores the immediate into the register (mod 11) or the memory word (mod 00) that its ModR/M byte selects. The ModR/M middle field has no effect.
- R8: Opcode 0x68 lowers register 4 by 4, then writes the immediate to memory at the lowered value.
- R9: An unlisted opcode causes an error. So do 0x81 with middle field 2 or 3, a ModR/M mod of 01 or 10, and mod 00 with rm 4 or 5. The error sets `err`, which then stays high, drops `in_ready`, and leaves registers unchanged until reset.
- R10: `done` is high for exactly one cycle per retired instruction, and `mem_rd` and `mem_wr` are never high together.
- R11: After reset all registers and flags read zero, `err` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Unit accepts a byte this cycle |
| mem_rd | output | 1 | Memory read request, held until `mem_rvalid` |
| mem_wr | output | 1 | One-cycle memory write strobe |
| mem_addr | output | DATA_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| done | output | 1 | Instruction retired this cycle |
| err | output | 1 | Sticky unsupported-encoding error |
| flag_sf | output | 1 | Sign flag |
| flag_zf | output | 1 | Zero flag |
| flag_of | output | 1 | Overflow flag |
| peek_idx | input | 3 | Register index for the peek port |
| peek_val | output | DATA_W | Value of register `peek_idx` |

## Verification
The bench builds the unit with its default parameters: a 32-bit data width and register 4 as the stack pointer. At this width the immediate spans four bytes, so every byte lane of the little-endian assembly is exercised, and bit 31 is the sign position that drives the compare-overflow case 0x80000000 minus 1. The memory model answers each read one cycle late, which places the read-wait state of the read-modify-write path directly on the checked path.

// File: rtl/immop_pkg.sv
package immop_pkg;

  // Operation codes match the ModR/M middle-field values of the group opcode.
  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_OR  = 3'd1,
    ALU_BD2 = 3'd2,
    ALU_BD3 = 3'd3,
    ALU_AND = 3'd4,
    ALU_SUB = 3'd5,
    ALU_XOR = 3'd6,
    ALU_CMP = 3'd7
  } aluop_e;

  typedef enum logic [2:0] {
    K_ALU_RM,
    K_ALU_ACC,
    K_MOV_REG,
    K_MOV_RM,
    K_PUSH,
    K_BAD
  } kind_e;

  typedef enum logic [2:0] {
    ST_OP,
    ST_MODRM,
    ST_IMM,
    ST_EXEC,
    ST_MRD,
    ST_MWR,
    ST_HALT
  } state_e;

endpackage

// File: rtl/immop_decode.sv
module immop_decode
  import immop_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int SP_IDX = 4
) (
  input  logic [7:0]       opcode,
  input  logic [7:0]       modrm,
  input  kind_e            cur_kind,
  output kind_e            op_kind,
  output aluop_e           op_alu,
  output logic [IDX_W-1:0] op_dst,
  output logic             mr_ok,
  output logic             mr_mem,
  output aluop_e           mr_alu,
  output logic [IDX_W-1:0] mr_rm
);

  // First-byte classification
  always_comb begin
    op_kind = K_BAD;
    op_alu  = ALU_ADD;
    op_dst  = '0;
    casez (opcode)
      8'h81: op_kind = K_ALU_RM;
      8'hc7: op_kind = K_MOV_RM;
      8'h2d: begin op_kind = K_ALU_ACC; op_alu = ALU_SUB; end
      8'h25: begin op_kind = K_ALU_ACC; op_alu = ALU_AND; end
      8'h0d: begin op_kind = K_ALU_ACC; op_alu = ALU_OR;  end
      8'h35: begin op_kind = K_ALU_ACC; op_alu = ALU_XOR; end
      8'h3d: begin op_kind = K_ALU_ACC; op_alu = ALU_CMP; end
      8'b1011_1???: begin
        op_kind = K_MOV_REG;
        op_dst  = opcode[IDX_W-1:0];
      end
      8'h68: begin
        op_kind = K_PUSH;
        op_dst  = IDX_W'(SP_IDX);
      end
      default: op_kind = K_BAD;
    endcase
  end

  // ModR/M byte checks
  logic [1:0] md;
  logic       mode_ok;
  logic       sub_ok;

  assign md     = modrm[7:6];
  assign mr_rm  = modrm[IDX_W-1:0];
  assign mr_alu = aluop_e'(modrm[5:3]);
  assign mr_mem = (md == 2'b00);

  always_comb begin
    mode_ok = 1'b0;
    if (md == 2'b11) begin
      mode_ok = 1'b1;
    end else if (md == 2'b00) begin
      mode_ok = (modrm[2:0] != 3'd4) && (modrm[2:0] != 3'd5);
    end
    sub_ok = 1'b1;
    if (cur_kind == K_ALU_RM) begin
      sub_ok = (modrm[5:3] != 3'd2) && (modrm[5:3] != 3'd3);
    end
    mr_ok = mode_ok && sub_ok;
  end

endmodule

// File: rtl/immop_alu.sv
module immop_alu
  import immop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  aluop_e            op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              sf,
  output logic              zf,
  output logic              of
);

  logic [DATA_W-1:0] diff;

  assign diff = a - b;

  always_comb begin
    case (op)
      ALU_ADD: res = a + b;
      ALU_OR:  res = a | b;
      ALU_AND: res = a & b;
      ALU_SUB: res = diff;
      ALU_XOR: res = a ^ b;
      default: res = a;
    endcase
  end

  // Compare flags come from the truncated difference.
  assign sf = diff[DATA_W-1];
  assign zf = (diff == '0);
  assign of = (a[DATA_W-1] ^ b[DATA_W-1]) & (diff[DATA_W-1] ^ a[DATA_W-1]);

endmodule

// File: rtl/immop_regs.sv
module immop_regs #(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  parameter int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] gpr_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic en;
    assign en = we && (waddr == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gpr_q[g] <= '0;
      end else if (en) begin
        gpr_q[g] <= wdata;
      end
    end
  end

  assign rdata_a = gpr_q[raddr_a];
  assign rdata_b = gpr_q[raddr_b];

  AST_WADDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !$isunknown(waddr)); // R6

endmodule

// File: rtl/immop_exec.sv
module immop_exec
  import immop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SP_IDX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              err,
  output logic              flag_sf,
  output logic              flag_zf,
  output logic              flag_of,
  input  logic [2:0]        peek_idx,
  output logic [DATA_W-1:0] peek_val
);

  localparam int NREG      = 8;
  localparam int IDX_W     = 3;
  localparam int IMM_BYTES = DATA_W / 8;
  localparam int CNT_W     = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(IMM_BYTES - 1);
  localparam logic [DATA_W-1:0] SP_STEP  = DATA_W'(IMM_BYTES);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_i_n = rsync_q[1];

  // State
  state_e            state_q, state_d;
  kind_e             kind_q, kind_d;
  aluop_e            aop_q, aop_d;
  logic [IDX_W-1:0]  dst_q, dst_d;
  logic              ismem_q, ismem_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] imm_q, imm_d;
  logic [DATA_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              sf_q, sf_d, zf_q, zf_d, of_q, of_d;
  logic              err_q, err_d;

  logic              ctl_en, imm_en, addr_en, res_en, flg_en, err_en;

  // Decoder
  kind_e             dc_kind;
  aluop_e            dc_alu, mr_alu;
  logic [IDX_W-1:0]  dc_dst, mr_rm;
  logic              mr_ok, mr_mem;

  immop_decode #(.IDX_W(IDX_W), .SP_IDX(SP_IDX)) u_dec (
    .opcode   (in_byte),
    .modrm    (in_byte),
    .cur_kind (kind_q),
    .op_kind  (dc_kind),
    .op_alu   (dc_alu),
    .op_dst   (dc_dst),
    .mr_ok    (mr_ok),
    .mr_mem   (mr_mem),
    .mr_alu   (mr_alu),
    .mr_rm    (mr_rm)
  );

  // Register file
  logic              rf_we;
  logic [IDX_W-1:0]  rf_waddr;
  logic [DATA_W-1:0] rf_wdata;
  logic [DATA_W-1:0] rf_a;

  immop_regs #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (dst_q),
    .rdata_a (rf_a),
    .raddr_b (peek_idx),
    .rdata_b (peek_val)
  );

  // ALU: operand from memory while waiting on a read, else from the register
  logic [DATA_W-1:0] alu_a, alu_res;
  logic              alu_sf, alu_zf, alu_of;

  assign alu_a = (state_q == ST_MRD) ? mem_rdata : rf_a;

  immop_alu #(.DATA_W(DATA_W)) u_alu (
    .op  (aop_q),
    .a   (alu_a),
    .b   (imm_q),
    .res (alu_res),
    .sf  (alu_sf),
    .zf  (alu_zf),
    .of  (alu_of)
  );

  logic accept;
  assign in_ready = (state_q == ST_OP) || (state_q == ST_MODRM) || (state_q == ST_IMM);
  assign accept   = in_valid && in_ready;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    aop_d    = aop_q;
    dst_d    = dst_q;
    ismem_d  = ismem_q;
    cnt_d    = cnt_q;
    imm_d    = imm_q;
    addr_d   = addr_q;
    res_d    = res_q;
    sf_d     = sf_q;
    zf_d     = zf_q;
    of_d     = of_q;
    err_d    = err_q;
    ctl_en   = 1'b0;
    imm_en   = 1'b0;
    addr_en  = 1'b0;
    res_en   = 1'b0;
    flg_en   = 1'b0;
    err_en   = 1'b0;
    rf_we    = 1'b0;
    rf_waddr = dst_q;
    rf_wdata = alu_res;
    done     = 1'b0;
    mem_rd   = 1'b0;
    mem_wr   = 1'b0;

    case (state_q)
      ST_OP: begin
        if (accept) begin
          ctl_en  = 1'b1;
          kind_d  = dc_kind;
          aop_d   = dc_alu;
          dst_d   = dc_dst;
          ismem_d = 1'b0;
          cnt_d   = '0;
          if (dc_kind == K_BAD) begin
            err_en  = 1'b1;
            err_d   = 1'b1;
            state_d = ST_HALT;
          end else if ((dc_kind == K_ALU_RM) || (dc_kind == K_MOV_RM)) begin
            state_d = ST_MODRM;
          end else begin
            state_d = ST_IMM;
          end
        end
      end

      ST_MODRM: begin
        if (accept) begin
          ctl_en = 1'b1;
          if (!mr_ok) begin
            err_en  = 1'b1;
            err_d   = 1'b1;
            state_d = ST_HALT;
          end else begin
            dst_d   = mr_rm;
            ismem_d = mr_mem;
            if (kind_q == K_ALU_RM) begin
              aop_d = mr_alu;
            end
            state_d = ST_IMM;
          end
        end
      end

      ST_IMM: begin
        if (accept) begin
          ctl_en = 1'b1;
          imm_en = 1'b1;
          imm_d  = {in_byte, imm_q[DATA_W-1:8]};
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            state_d = ST_EXEC;
          end
        end
      end

      ST_EXEC: begin
        ctl_en = 1'b1;
        case (kind_q)
          K_ALU_RM, K_ALU_ACC: begin
            if (ismem_q) begin
              addr_en = 1'b1;
              addr_d  = rf_a;
              state_d = ST_MRD;
            end else begin
              if (aop_q == ALU_CMP) begin
                flg_en = 1'b1;
                sf_d   = alu_sf;
                zf_d   = alu_zf;
                of_d   = alu_of;
              end else begin
                rf_we = 1'b1;
              end
              done    = 1'b1;
              state_d = ST_OP;
            end
          end
          K_MOV_REG: begin
            rf_we    = 1'b1;
            rf_wdata = imm_q;
            done     = 1'b1;
            state_d  = ST_OP;
          end
          K_MOV_RM: begin
            if (ismem_q) begin
              addr_en = 1'b1;
              addr_d  = rf_a;
              res_en  = 1'b1;
              res_d   = imm_q;
              state_d = ST_MWR;
            end else begin
              rf_we    = 1'b1;
              rf_wdata = imm_q;
              done     = 1'b1;
              state_d  = ST_OP;
            end
          end
          K_PUSH: begin
            rf_we    = 1'b1;
            rf_wdata = rf_a - SP_STEP;
            addr_en  = 1'b1;
            addr_d   = rf_a - SP_STEP;
            res_en   = 1'b1;
            res_d    = imm_q;
            state_d  = ST_MWR;
          end
          default: begin
            err_en  = 1'b1;
            err_d   = 1'b1;
            state_d = ST_HALT;
          end
        endcase
      end

      ST_MRD: begin
        mem_rd = 1'b1;
        if (mem_rvalid) begin
          ctl_en = 1'b1;
          if (aop_q == ALU_CMP) begin
            flg_en  = 1'b1;
            sf_d    = alu_sf;
            zf_d    = alu_zf;
            of_d    = alu_of;
            done    = 1'b1;
            state_d = ST_OP;
          end else begin
            res_en  = 1'b1;
            res_d   = alu_res;
            state_d = ST_MWR;
          end
        end
      end

      ST_MWR: begin
        ctl_en  = 1'b1;
        mem_wr  = 1'b1;
        done    = 1'b1;
        state_d = ST_OP;
      end

      default: begin
        state_d = ST_HALT;
      end
    endcase
  end

  // Register processes
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_OP;
      kind_q  <= K_BAD;
      aop_q   <= ALU_ADD;
      dst_q   <= '0;
      ismem_q <= 1'b0;
      cnt_q   <= '0;
    end else if (ctl_en) begin
      state_q <= state_d;
      kind_q  <= kind_d;
      aop_q   <= aop_d;
      dst_q   <= dst_d;
      ismem_q <= ismem_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      imm_q <= '0;
    end else if (imm_en) begin
      imm_q <= imm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sf_q <= 1'b0;
      zf_q <= 1'b0;
      of_q <= 1'b0;
    end else if (flg_en) begin
      sf_q <= sf_d;
      zf_q <= zf_d;
      of_q <= of_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = res_q;
  assign err       = err_q;
  assign flag_sf   = sf_q;
  assign flag_zf   = zf_q;
  assign flag_of   = of_q;

  // Assertions
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(mem_rd && mem_wr)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_i_n)
    err |=> err); // R9

  AST_HALT_NO_INTAKE: assert property (@(posedge clk) disable iff (!rst_i_n)
    err |-> !in_ready); // R9

  AST_RMW_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_wr && (kind_q == K_ALU_RM)) |-> $past(mem_rd && mem_rvalid)); // R5

  AST_PUSH_AT_NEW_SP: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_wr && (kind_q == K_PUSH)) |-> (mem_addr == rf_a)); // R8

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (aop_q == ALU_CMP && (kind_q == K_ALU_RM || kind_q == K_ALU_ACC)) |-> !mem_wr); // R4

endmodule

// File: tb/immop_exec_tb.sv
`timescale 1ns/1ps
module immop_exec_tb;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        in_ready;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        done, err;
  logic        flag_sf, flag_zf, flag_of;
  logic [2:0]  peek_idx;
  logic [31:0] peek_val;

  int checks;
  int errors;
  bit finished;

  immop_exec u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .in_ready   (in_ready),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .done       (done),
    .err        (err),
    .flag_sf    (flag_sf),
    .flag_zf    (flag_zf),
    .flag_of    (flag_of),
    .peek_idx   (peek_idx),
    .peek_val   (peek_val)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Memory model: 16 words, addressed by byte address bits [5:2]
  logic [31:0] mem [16];
  logic        pre_we;
  logic [3:0]  pre_idx;
  logic [31:0] pre_val;
  int          wr_count;

  always @(posedge clk) begin
    mem_rvalid <= mem_rd && !mem_rvalid;
    mem_rdata  <= mem[mem_addr[5:2]];
    if (mem_wr) begin
      mem[mem_addr[5:2]] <= mem_wdata;
      wr_count <= wr_count + 1;
    end else if (pre_we) begin
      mem[pre_idx] <= pre_val;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    in_byte  = 8'h00;
    peek_idx = 3'd0;
    pre_we   = 1'b0;
    pre_idx  = 4'd0;
    pre_val  = '0;
    rst_n    = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic poke_mem(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    pre_we = 1'b1; pre_idx = idx; pre_val = val;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_imm(input logic [31:0] v, input int gap);
    for (int i = 0; i < 4; i++) send(v[8*i +: 8], gap);
  endtask

  // Waits for the retire pulse, checks it lasts one cycle (R10).
  task automatic wait_done(input string req);
    int n = 0;
    @(negedge clk);
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(req, "done seen", {31'd0, done}, 32'd1);
    @(negedge clk);
    chk("R10", "done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic get_reg(input logic [2:0] idx, output logic [31:0] v);
    @(negedge clk);
    peek_idx = idx;
    #1 v = peek_val;
  endtask

  task automatic mov_reg(input logic [2:0] idx, input logic [31:0] v);
    send({5'b10111, idx}, 0);
    send_imm(v, 0);
    wait_done("R6");
  endtask

  task automatic check_reg(input string req, input logic [2:0] idx, input logic [31:0] exp);
    logic [31:0] v;
    get_reg(idx, v);
    chk(req, $sformatf("reg%0d", idx), v, exp);
  endtask

  task automatic check_flags(input string req, input logic [2:0] exp);
    @(negedge clk);
    chk(req, "flags sf,zf,of", {29'd0, flag_sf, flag_zf, flag_of}, {29'd0, exp});
  endtask

  // Scenario tasks
  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      get_reg(3'(i), v);
      chk("R11", "reset reg", v, 32'd0);
    end
    check_flags("R11", 3'b000);
    chk("R11", "err", {31'd0, err}, 32'd0);
    chk("R11", "in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_mov_reg();
    for (int i = 0; i < 8; i++) mov_reg(3'(i), 32'h1111_1111 * (i + 1));
    for (int i = 0; i < 8; i++) check_reg("R6", 3'(i), 32'h1111_1111 * (i + 1));
    // R1: gaps between bytes, little-endian assembly
    send(8'hbb, 2);
    send_imm(32'h0d0c0b0a, 3);
    wait_done("R1");
    check_reg("R1", 3'd3, 32'h0d0c0b0a);
  endtask

  task automatic grp_reg(input logic [7:0] modrm, input logic [31:0] init, input logic [31:0] imm,
                         input logic [31:0] exp, input string req);
    mov_reg(3'd3, init);
    send(8'h81, 0);
    send(modrm, 0);
    send_imm(imm, 0);
    wait_done(req);
    check_reg(req, 3'd3, exp);
  endtask

  task automatic t_group_reg();
    // set SF first, to see ALU ops keep flags (R4)
    mov_reg(3'd0, 32'd1);
    send(8'h3d, 0); send_imm(32'd2, 0); wait_done("R4");
    check_flags("R4", 3'b100);
    grp_reg(8'hc3, 32'd1,          32'h0d0c0b0a, 32'h0d0c0b0b, "R2");
    grp_reg(8'hcb, 32'hd0c0b0a0,   32'h0d0c0b0a, 32'hddccbbaa, "R2");
    grp_reg(8'he3, 32'h000000ff,   32'h0d0c0b0a, 32'h0000000a, "R2");
    grp_reg(8'heb, 32'd10,         32'd1,        32'd9,        "R2");
    grp_reg(8'hf3, 32'hd0c0b0a0,   32'h0d0c0b0a, 32'hddccbbaa, "R2");
    check_flags("R4", 3'b100);
  endtask

  task automatic acc(input logic [7:0] opc, input logic [31:0] init, input logic [31:0] imm,
                     input logic [31:0] exp);
    mov_reg(3'd0, init);
    send(opc, 0);
    send_imm(imm, 0);
    wait_done("R3");
    check_reg("R3", 3'd0, exp);
  endtask

  task automatic t_acc();
    acc(8'h2d, 32'h0d0c0baa, 32'h0d0c0b0a, 32'h000000a0);
    acc(8'h25, 32'h000000ff, 32'h0d0c0b0a, 32'h0000000a);
    acc(8'h0d, 32'hd0c0b0a0, 32'h0d0c0b0a, 32'hddccbbaa);
    acc(8'h35, 32'hddccb0a0, 32'h0d0c0b0a, 32'hd0c0bbaa);
  endtask

  task automatic cmp_acc(input logic [31:0] a, input logic [31:0] imm, input logic [2:0] exp);
    mov_reg(3'd0, a);
    send(8'h3d, 0);
    send_imm(imm, 0);
    wait_done("R4");
    check_flags("R4", exp);
    check_reg("R4", 3'd0, a);
  endtask

  task automatic t_compare();
    cmp_acc(32'h0d0c0b0a, 32'h0d0c0b07, 3'b000);
    cmp_acc(32'h0d0c0b07, 32'h0d0c0b0a, 3'b100);
    cmp_acc(32'h0d0c0b0a, 32'h0d0c0b0a, 3'b010);
    cmp_acc(32'h80000000, 32'h00000001, 3'b001);
    // register form through the group opcode
    mov_reg(3'd3, 32'h0d0c0b07);
    send(8'h81, 0); send(8'hfb, 0); send_imm(32'h0d0c0b0a, 0);
    wait_done("R4");
    check_flags("R4", 3'b100);
    check_reg("R4", 3'd3, 32'h0d0c0b07);
  endtask

  task automatic t_memory();
    int w0;
    mov_reg(3'd3, 32'h20);
    poke_mem(4'd8, 32'd1);
    w0 = wr_count;
    send(8'h81, 0); send(8'h03, 0); send_imm(32'h0d0c0b0a, 0);
    wait_done("R5");
    chk("R5", "mem add result", mem[8], 32'h0d0c0b0b);
    chk("R5", "one write", 32'(wr_count - w0), 32'd1);
    // subtract in memory
    poke_mem(4'd8, 32'd10);
    send(8'h81, 0); send(8'h2b, 0); send_imm(32'd1, 0);
    wait_done("R5");
    chk("R5", "mem sub result", mem[8], 32'd9);
    // compare against memory: flags only, no write
    poke_mem(4'd8, 32'h0d0c0b07);
    w0 = wr_count;
    send(8'h81, 0); send(8'h3b, 0); send_imm(32'h0d0c0b0a, 0);
    wait_done("R5");
    check_flags("R5", 3'b100);
    chk("R5", "cmp no write", 32'(wr_count - w0), 32'd0);
    chk("R5", "cmp mem kept", mem[8], 32'h0d0c0b07);
  endtask

  task automatic t_mov_rm();
    mov_reg(3'd3, 32'h24);
    send(8'hc7, 0); send(8'h03, 0); send_imm(32'h0d0c0b0a, 0);
    wait_done("R7");
    chk("R7", "mov to mem", mem[9], 32'h0d0c0b0a);
    // middle field 7 must not matter: mod 11, rm 0
    send(8'hc7, 0); send(8'hf8, 0); send_imm(32'hcafe0001, 0);
    wait_done("R7");
    check_reg("R7", 3'd0, 32'hcafe0001);
  endtask

  task automatic t_push();
    mov_reg(3'd4, 32'h14);
    send(8'h68, 0); send_imm(32'h000000af, 0);
    wait_done("R8");
    check_reg("R8", 3'd4, 32'h10);
    chk("R8", "pushed word", mem[4], 32'h000000af);
  endtask

  task automatic t_error(input logic [7:0] b0, input logic [7:0] b1, input bit two);
    do_reset();
    mov_reg(3'd3, 32'h5555aaaa);
    send(b0, 0);
    if (two) send(b1, 0);
    @(negedge clk);
    chk("R9", "err raised", {31'd0, err}, 32'd1);
    chk("R9", "in_ready low", {31'd0, in_ready}, 32'd0);
    // further bytes are refused and state stays
    in_valid = 1'b1; in_byte = 8'hbb;
    repeat (6) @(negedge clk);
    in_valid = 1'b0;
    chk("R9", "err sticky", {31'd0, err}, 32'd1);
    check_reg("R9", 3'd3, 32'h5555aaaa);
  endtask

  initial begin
    int cyc = 0;
    @(posedge clk);
    while (!finished && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; finished = 0; wr_count = 0;
    mem_rvalid = 1'b0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    do_reset();
    t_reset();
    t_mov_reg();
    t_group_reg();
    t_acc();
    t_compare();
    t_memory();
    t_mov_rm();
    t_push();
    t_error(8'h90, 8'h00, 1'b0);
    t_error(8'h81, 8'hd3, 1'b1);
    t_error(8'h81, 8'h43, 1'b1);
    t_error(8'hc7, 8'h04, 1'b1);
    do_reset();
    chk("R11", "err cleared", {31'd0, err}, 32'd0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule